// File: doc/BRIEF.md
# Thermal Throttling Stop-Clock Generator

This block sits on the system side of a processor link and drives an active-low stop-clock line (`stop_clk_n`). Three sources can pull the line low. An active-low thermal alarm starts hardware throttling, which uses a fixed half duty. Software can start throttling at a duty it chooses by writing a throttle control register. A read of the level-2 register places the processor in the C2 state. While throttling, the line is held low for the first duty/8 of every fixed-length period and is released for the rest of the period. This repeats for as long as a throttling source stays active.

Software sees a small register interface with a one-cycle write strobe, a one-cycle read strobe, an address and data. The status register shows whether throttling or C2 is active. C2 holds the line low until a wake pulse arrives, and C2 overrides the throttling pattern.

Top module: `stopclk_gen`

## Requirements
- R1: After a synchronous reset, `stop_clk_n` is 1, the control register reads 0 and the status register reads 0.
- R2: While `therm_alarm_n` is low and the control enable bit is 0, `stop_clk_n` is low for exactly 128 of every 256 cycles. The alarm passes through a two-flip-flop synchronizer.
- R3: Once `therm_alarm_n` returns high with the enable bit clear, throttling ends at the next period boundary. From then on `stop_clk_n` stays high and status bit 0 reads 0.
- R4: With the enable bit (control bit 3) set and a duty d in control bits 2:0, `stop_clk_n` is low for d*32 of every 256 cycles. This holds whatever the level of the alarm.
- R5: With the enable bit set and a duty of 0, there is no throttling, even while the alarm is active.
- R6: A duty change written in the middle of a period leaves that period unchanged. The new duty applies from the next boundary. Each low window starts at the first cycle of a period.
- R7: A read strobe at address 1 sets C2. `stop_clk_n` goes low on the next edge after C2 is set and stays low until a wake pulse.
- R8: While C2 is active, `stop_clk_n` stays low for the whole throttling period, high window included.
- R9: A `wake_evt` pulse clears C2. If no throttling is active, `stop_clk_n` returns high one cycle later. A level-2 read in the same cycle as a wake wins.
- R10: A read at address 2 returns status with bit 0 = throttling active and bit 1 = C2 active. `reg_rdata` is valid on the edge after the read strobe.
- R11: The control register at address 0 reads back {4'b0, enable, duty}. Writes to any other address change nothing.
- R12: Reads at addresses 0, 2 and 3 do not enter C2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| therm_alarm_n | input | 1 | Asynchronous active-low thermal alarm |
| wake_evt | input | 1 | One-cycle wake pulse that ends C2 |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 2 | Register address (0 control, 1 level-2, 2 status) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, registered |
| stop_clk_n | output | 1 | Active-low stop-clock to the processor |

## Verification
An alarm edge needs two synchronizer cycles and one period-latch cycle before the pattern starts. The output register adds one more cycle. Rather than pin the exact phase, the bench waits 600 cycles after each duty or alarm change and then counts low samples across one full 256-cycle window, which gives duty*32 whatever the phase. C2 entry and exit take effect on `stop_clk_n` one cycle after the strobe's edge, and read data is due on the edge after the read strobe; the bench samples at the falling edge that follows each of those edges. The boundary test first finds a falling edge of `stop_clk_n` and counts samples from it. This pins down exactly when a mid-period duty change first appears.

// File: rtl/stopclk_pkg.sv
package stopclk_pkg;

    localparam int DUTY_W = 3;
    localparam int ADDR_W = 2;
    localparam int DATA_W = 8;

    localparam logic [DUTY_W-1:0] HW_DUTY   = DUTY_W'(4);
    localparam logic [ADDR_W-1:0] ADDR_CTRL = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] ADDR_LVL2 = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] ADDR_STAT = ADDR_W'(2);

    typedef struct packed {
        logic              en;
        logic [DUTY_W-1:0] duty;
    } thr_ctrl_t;

    typedef struct packed {
        logic c2;
        logic thr;
    } stat_t;

    // Software setting wins; otherwise the alarm selects the fixed default.
    function automatic logic [DUTY_W-1:0] pick_duty(thr_ctrl_t c, logic alarm);
        if (c.en)
            return c.duty;
        else if (alarm)
            return HW_DUTY;
        else
            return '0;
    endfunction

endpackage

// File: rtl/stopclk_sync.sv
module stopclk_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d_n,
    output logic q_n
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) chain <= '1;
                else     chain <= d_n;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst) chain <= '1;
                else     chain <= {chain[STAGES-2:0], d_n};
            end
        end
    endgenerate

    assign q_n = chain[STAGES-1];
endmodule

// File: rtl/stopclk_regs.sv
module stopclk_regs
    import stopclk_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic              rd,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              wake,
    input  logic              thr_act,
    output thr_ctrl_t         ctrl,
    output logic              c2_act,
    output logic [DATA_W-1:0] rdata
);
    localparam int CTRL_W = $bits(thr_ctrl_t);
    localparam int STAT_W = $bits(stat_t);

    stat_t stat;
    assign stat = '{c2: c2_act, thr: thr_act};

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl   <= '0;
            c2_act <= 1'b0;
            rdata  <= '0;
        end else begin
            if (wr && addr == ADDR_CTRL)
                ctrl <= thr_ctrl_t'(wdata[CTRL_W-1:0]);

            if (rd && addr == ADDR_LVL2)
                c2_act <= 1'b1;
            else if (wake)
                c2_act <= 1'b0;

            if (rd) begin
                case (addr)
                    ADDR_CTRL: rdata <= {{(DATA_W-CTRL_W){1'b0}}, ctrl};
                    ADDR_STAT: rdata <= {{(DATA_W-STAT_W){1'b0}}, stat};
                    default:   rdata <= '0;
                endcase
            end
        end
    end
endmodule

// File: rtl/stopclk_pattern.sv
module stopclk_pattern
    import stopclk_pkg::*;
#(
    parameter int PERIOD = 256
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [DUTY_W-1:0]         duty_req,
    output logic [DUTY_W-1:0]         lat_duty,
    output logic [$clog2(PERIOD)-1:0] cnt,
    output logic                      thr_stop
);
    localparam int CNT_W = $clog2(PERIOD);
    localparam int LIM_W = CNT_W + 1;
    localparam int SEG   = PERIOD >> DUTY_W;

    logic             idle;
    logic             at_end;
    logic [LIM_W-1:0] limit;

    assign idle   = (lat_duty == '0);
    assign at_end = (cnt == CNT_W'(PERIOD - 1));
    assign limit  = LIM_W'(lat_duty) * LIM_W'(SEG);

    always_ff @(posedge clk) begin
        if (rst) begin
            lat_duty <= '0;
            cnt      <= '0;
        end else if (idle) begin
            lat_duty <= duty_req;
            cnt      <= '0;
        end else if (at_end) begin
            lat_duty <= duty_req;
            cnt      <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign thr_stop = !idle && (LIM_W'(cnt) < limit);
endmodule

// File: rtl/stopclk_gen.sv
module stopclk_gen
    import stopclk_pkg::*;
#(
    parameter int PERIOD      = 256,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              therm_alarm_n,
    input  logic              wake_evt,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              stop_clk_n
);
    localparam int CNT_W = $clog2(PERIOD);

    logic              alarm_sn;
    logic              alarm;
    thr_ctrl_t         ctrl;
    logic              c2_act;
    logic [DUTY_W-1:0] duty_req;
    logic [DUTY_W-1:0] lat_duty;
    logic [CNT_W-1:0]  cnt;
    logic              thr_stop;
    logic              thr_act;

    stopclk_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d_n (therm_alarm_n),
        .q_n (alarm_sn)
    );
    assign alarm = ~alarm_sn;

    assign duty_req = pick_duty(ctrl, alarm);
    assign thr_act  = (lat_duty != '0);

    stopclk_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr      (reg_wr),
        .rd      (reg_rd),
        .addr    (reg_addr),
        .wdata   (reg_wdata),
        .wake    (wake_evt),
        .thr_act (thr_act),
        .ctrl    (ctrl),
        .c2_act  (c2_act),
        .rdata   (reg_rdata)
    );

    stopclk_pattern #(.PERIOD(PERIOD)) u_pat (
        .clk      (clk),
        .rst      (rst),
        .duty_req (duty_req),
        .lat_duty (lat_duty),
        .cnt      (cnt),
        .thr_stop (thr_stop)
    );

    always_ff @(posedge clk) begin
        if (rst) stop_clk_n <= 1'b1;
        else     stop_clk_n <= ~(c2_act | thr_stop);
    end
endmodule

// File: rtl/stopclk_chk.sv
module stopclk_chk
    import stopclk_pkg::*;
#(
    parameter int PERIOD = 256
) (
    input logic                      clk,
    input logic                      rst,
    input logic                      stop_clk_n,
    input logic                      reg_rd,
    input logic [ADDR_W-1:0]         reg_addr,
    input logic [DATA_W-1:0]         reg_rdata,
    input logic                      wake_evt,
    input logic                      c2_act,
    input logic [DUTY_W-1:0]         lat_duty,
    input logic [$clog2(PERIOD)-1:0] cnt
);
    localparam int CNT_W = $clog2(PERIOD);

    p_reset_r1: assert property (@(posedge clk)
        rst |=> (stop_clk_n && reg_rdata == '0));

    p_c2_entry_r7: assert property (@(posedge clk) disable iff (rst)
        (reg_rd && reg_addr == ADDR_LVL2) |=> c2_act);

    p_c2_priority_r8: assert property (@(posedge clk) disable iff (rst)
        c2_act |=> !stop_clk_n);

    p_wake_release_r9: assert property (@(posedge clk) disable iff (rst)
        (wake_evt && !(reg_rd && reg_addr == ADDR_LVL2)) |=> !c2_act);

    p_duty_boundary_r6: assert property (@(posedge clk) disable iff (rst)
        (lat_duty != '0 && cnt != CNT_W'(PERIOD - 1)) |=> $stable(lat_duty));

    p_status_c2_r10: assert property (@(posedge clk) disable iff (rst)
        (reg_rd && reg_addr == ADDR_STAT) |=> (reg_rdata[1] == $past(c2_act)));

    p_no_c2_other_r12: assert property (@(posedge clk) disable iff (rst)
        (!c2_act && !(reg_rd && reg_addr == ADDR_LVL2)) |=> !c2_act);
endmodule

bind stopclk_gen stopclk_chk #(.PERIOD(PERIOD)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .stop_clk_n (stop_clk_n),
    .reg_rd     (reg_rd),
    .reg_addr   (reg_addr),
    .reg_rdata  (reg_rdata),
    .wake_evt   (wake_evt),
    .c2_act     (c2_act),
    .lat_duty   (lat_duty),
    .cnt        (cnt)
);

// File: tb/sim_stopclk_gen.sv
module sim_stopclk_gen;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       therm_alarm_n = 1'b1;
    logic       wake_evt = 1'b0;
    logic       reg_wr = 1'b0;
    logic       reg_rd = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;
    logic       stop_clk_n;

    int checks = 0;
    int errors = 0;

    stopclk_gen u0 (
        .clk           (clk),
        .rst           (rst),
        .therm_alarm_n (therm_alarm_n),
        .wake_evt      (wake_evt),
        .reg_wr        (reg_wr),
        .reg_rd        (reg_rd),
        .reg_addr      (reg_addr),
        .reg_wdata     (reg_wdata),
        .reg_rdata     (reg_rdata),
        .stop_clk_n    (stop_clk_n)
    );

    always #10 clk = ~clk;

    // {enable, duty, alarm active, expected low cycles per 256}
    localparam int NVEC = 8;
    localparam logic [16:0] VEC [NVEC] = '{
        {1'b0, 3'd0, 1'b1, 12'd128},
        {1'b1, 3'd6, 1'b0, 12'd192},
        {1'b1, 3'd1, 1'b1, 12'd32},
        {1'b1, 3'd0, 1'b1, 12'd0},
        {1'b0, 3'd5, 1'b0, 12'd0},
        {1'b1, 3'd7, 1'b0, 12'd224},
        {1'b0, 3'd3, 1'b1, 12'd128},
        {1'b1, 3'd4, 1'b0, 12'd128}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] v);
        reg_rd = 1'b1; reg_addr = a;
        @(negedge clk);
        v = reg_rdata;
        reg_rd = 1'b0;
    endtask

    task automatic count_low(input int n, output int c);
        c = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (!stop_clk_n) c++;
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        logic [7:0] v;
        int         lows;
        int         highs;

        cyc(3);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(stop_clk_n == 1'b1, "R1 stop after reset", stop_clk_n, 1);
        rd(2'd0, v);
        check(v == 8'd0, "R1 control after reset", v, 0);
        rd(2'd2, v);
        check(v == 8'd0, "R1 status after reset", v, 0);

        // Table walk: R2 hardware default, R4 software duty, R5 zero duty
        for (int k = 0; k < NVEC; k++) begin
            wr(2'd0, {4'b0, VEC[k][16], VEC[k][15:13]});
            therm_alarm_n = ~VEC[k][12];
            cyc(600);
            count_low(256, lows);
            check(lows == int'(VEC[k][11:0]), "R2/R4/R5 low cycles per period",
                  lows, int'(VEC[k][11:0]));
            rd(2'd2, v);
            check(v[0] == (VEC[k][11:0] != 0), "R10 throttle status bit",
                  v[0], int'(VEC[k][11:0] != 0));
        end

        // R3: alarm removed, enable clear
        wr(2'd0, 8'h00);
        therm_alarm_n = 1'b0;
        cyc(600);
        therm_alarm_n = 1'b1;
        cyc(600);
        count_low(256, lows);
        check(lows == 0, "R3 no throttle after alarm release", lows, 0);
        rd(2'd2, v);
        check(v[0] == 1'b0, "R3 throttle status clear", v[0], 0);

        // R11 readback and masking, writes elsewhere ignored
        wr(2'd0, 8'hFD);
        rd(2'd0, v);
        check(v == 8'h0D, "R11 control readback", v, 8'h0D);
        wr(2'd3, 8'h0A);
        wr(2'd2, 8'h0A);
        wr(2'd1, 8'h0A);
        rd(2'd0, v);
        check(v == 8'h0D, "R11 other-address write ignored", v, 8'h0D);

        // R6 duty change lands only at the next boundary
        wr(2'd0, 8'h0A);      // enable, duty 2
        cyc(600);
        while (stop_clk_n == 1'b0) @(negedge clk);
        while (stop_clk_n == 1'b1) @(negedge clk);
        // this negedge is sample index 0 of a period
        cyc(99);
        wr(2'd0, 8'h0E);      // duty 6, mid-period (index 100)
        count_low(155, lows); // indices 101..255
        check(lows == 0, "R6 current period unchanged", lows, 0);
        @(negedge clk);       // index 256
        check(stop_clk_n == 1'b0, "R6 new window at boundary", stop_clk_n, 0);
        count_low(255, lows);
        check(lows == 191, "R6 new duty after boundary", lows, 191);

        // R8: C2 overrides throttling
        wr(2'd0, 8'h0A);
        cyc(600);
        rd(2'd1, v);
        highs = 0;
        cyc(1);
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            if (stop_clk_n) highs++;
        end
        check(highs == 0, "R8 C2 overrides throttle", highs, 0);
        rd(2'd2, v);
        check(v[1:0] == 2'b11, "R10 status both active", v[1:0], 3);
        wake_evt = 1'b1;
        @(negedge clk);
        wake_evt = 1'b0;
        wr(2'd0, 8'h00);
        cyc(600);

        // R7 C2 entry and hold, R9 wake release
        rd(2'd1, v);
        cyc(1);
        check(stop_clk_n == 1'b0, "R7 C2 asserts stop", stop_clk_n, 0);
        count_low(300, lows);
        check(lows == 300, "R7 C2 held without wake", lows, 300);
        wake_evt = 1'b1;
        @(negedge clk);
        wake_evt = 1'b0;
        @(negedge clk);
        check(stop_clk_n == 1'b1, "R9 wake releases stop", stop_clk_n, 1);
        rd(2'd2, v);
        check(v[1] == 1'b0, "R9 C2 status cleared", v[1], 0);

        // R9: level-2 read together with wake wins
        reg_rd = 1'b1; reg_addr = 2'd1; wake_evt = 1'b1;
        @(negedge clk);
        reg_rd = 1'b0; wake_evt = 1'b0;
        cyc(2);
        check(stop_clk_n == 1'b0, "R9 read wins over wake", stop_clk_n, 0);
        wake_evt = 1'b1;
        @(negedge clk);
        wake_evt = 1'b0;
        cyc(2);

        // R12 other reads do not enter C2
        rd(2'd0, v);
        rd(2'd2, v);
        rd(2'd3, v);
        cyc(2);
        check(stop_clk_n == 1'b1, "R12 no C2 from other reads", stop_clk_n, 1);
        rd(2'd2, v);
        check(v[1] == 1'b0, "R12 C2 status clear", v[1], 0);

        // R1 reset during throttling
        wr(2'd0, 8'h0F);
        cyc(300);
        rst = 1'b1;
        cyc(2);
        rst = 1'b0;
        @(negedge clk);
        check(stop_clk_n == 1'b1, "R1 reset mid-throttle", stop_clk_n, 1);
        rd(2'd0, v);
        check(v == 8'd0, "R1 control cleared by reset", v, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule